// File: doc/BRIEF.md
# PCI Slot Interrupt Router

This block turns level-sensitive interrupt requests from PCI slots into a vector of interrupt lines. Each request arrives as a one-cycle strobe that carries the device/function number of the source, the pin that is signalling (0 to 3) and the new level of that pin. Two bits of the device/function number select a slot, and the slot and the pin together pick one line of the output vector, so each slot owns four lines that sit next to each other.

The router keeps a stored level for every line, and the stored level changes only when a strobe selects that line. Each output line is its stored level gated by an enable bit. Groups of four lines share one enable bit, which comes from the interrupt-map registers outside this block. A level that arrives while its group is disabled is kept, and it shows on the output as soon as the group is enabled. Clearing the enables forces every output low. The line count, the group size and the position of the slot field are parameters. A request that maps beyond the last line is dropped.

Top module: `pci_irq_router`

## Requirements
- R1: A synchronous active-low reset clears every stored level, so with all groups enabled every output line reads 0 after the first clock edge with reset low.
- R2: When `req_valid` is high at a clock edge, line number devfn[4:3]*4 + pin takes `req_level` as its stored level, and every other stored level keeps its value.
- R3: When `req_valid` is low at a clock edge, no stored level changes.
- R4: Output line n shows its stored level whenever enable bit floor(n/4) of `grp_enable` is 1.
- R5: Output line n is 0 whenever enable bit floor(n/4) is 0, whatever its stored level, and a strobe to a line of a disabled group still updates that line's stored level.
- R6: Setting an enable bit exposes a level that is already stored, in the same cycle and with no new strobe.
- R7: Device/function bits other than [4:3] have no effect on which line a request selects.
- R8: In a build with fewer lines than the mapping can reach, a request whose line number is at or above the line count changes no stored level and no output.
- R9: In the default 32-line build, only lines 0 to 15 can be reached by a request, so lines 16 to 31 stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | One-cycle strobe marking a level change request |
| req_devfn | input | DEVFN_W (8) | Device/function number of the source; bits [4:3] pick the slot |
| req_pin | input | PIN_W (2) | Interrupt pin of the source, 0 to 3 |
| req_level | input | 1 | New level of that pin |
| grp_enable | input | NUM_GROUPS (8) | One enable bit per group of four lines |
| irq_out | output | NUM_LINES (32) | Gated interrupt level per line |

## Verification
The checker takes it as given that the request fields are known whenever `req_valid` is high, and that the enable vector only changes between clock edges. It also assumes that reset is held low from time zero until the first edge. The bench drives every input on the falling edge, so each field is stable well before the rising edge that samples it. It starts with reset asserted. One directed case changes the enable vector with no clock edge in between, to show that the output follows the enables combinationally. A second, 8-line instance receives requests that land above its last line, which checks that such requests are dropped.

// File: rtl/pci_irq_router_pkg.sv
// Package: shared constants for the PCI slot interrupt router.
// Assumes a slot field of two bits and four pins per slot by default.
package pci_irq_router_pkg;
    localparam int DEF_DEVFN_W     = 8;
    localparam int DEF_PIN_W       = 2;
    localparam int DEF_SLOT_LSB    = 3;
    localparam int DEF_SLOT_W      = 2;
    localparam int DEF_NUM_LINES   = 32;
    localparam int DEF_GROUP_LINES = 4;
endpackage

// File: rtl/irq_line_mapper.sv
// Module: irq_line_mapper
// Turns a request (devfn, pin) into a line number and a one-hot select.
// Assumes the line number is {slot field, pin}, i.e. slot*2^PIN_W + pin.
// Line numbers at or above NUM_LINES give no select and clear line_hit.
module irq_line_mapper #(
    parameter int DEVFN_W   = 8,
    parameter int PIN_W     = 2,
    parameter int SLOT_LSB  = 3,
    parameter int SLOT_W    = 2,
    parameter int NUM_LINES = 32,
    parameter int IDX_W     = SLOT_W + PIN_W
) (
    input  logic                 req_valid,
    input  logic [DEVFN_W-1:0]   req_devfn,
    input  logic [PIN_W-1:0]     req_pin,
    output logic [IDX_W-1:0]     line_idx,
    output logic                 line_hit,
    output logic [NUM_LINES-1:0] line_sel
);
    // Form the line number and its range check.
    always_comb begin
        line_idx = {req_devfn[SLOT_LSB +: SLOT_W], req_pin};
        line_hit = (32'(line_idx) < 32'(NUM_LINES));
    end

    // One select bit per line, set only for the addressed line.
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_sel
        always_comb begin
            line_sel[n] = req_valid && line_hit && (32'(line_idx) == 32'(n));
        end
    end
endmodule

// File: rtl/irq_level_store.sv
// Module: irq_level_store
// Holds the raw level of each line; a selected line loads the request level.
// Assumes at most one select bit is high per cycle. Synchronous active-low reset.
module irq_level_store #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_sel,
    input  logic                 req_level,
    output logic [NUM_LINES-1:0] raw_lines
);
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        // Per-line level register: clear on reset, load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_lines[n] <= 1'b0;
            end else if (line_sel[n]) begin
                raw_lines[n] <= req_level;
            end
        end
    end
endmodule

// File: rtl/irq_group_gate.sv
// Module: irq_group_gate
// Gates each stored level with the enable bit of its group of GROUP_LINES.
// Purely combinational, so an enable change shows on the same cycle.
module irq_group_gate #(
    parameter int NUM_LINES   = 32,
    parameter int GROUP_LINES = 4,
    parameter int NUM_GROUPS  = NUM_LINES / GROUP_LINES
) (
    input  logic [NUM_LINES-1:0]  raw_lines,
    input  logic [NUM_GROUPS-1:0] grp_enable,
    output logic [NUM_LINES-1:0]  irq_out
);
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_gate
        localparam int GRP = n / GROUP_LINES;
        // Output follows the stored level only while its group is enabled.
        always_comb begin
            irq_out[n] = raw_lines[n] & grp_enable[GRP];
        end
    end
endmodule

// File: rtl/pci_irq_router.sv
// Module: pci_irq_router (top)
// Routes level-sensitive PCI slot interrupt pins onto NUM_LINES gated lines.
// Assumes request fields are valid while req_valid is high and that the
// enable vector comes from registers elsewhere. Synchronous active-low reset.
module pci_irq_router
    import pci_irq_router_pkg::*;
#(
    parameter int DEVFN_W     = DEF_DEVFN_W,
    parameter int PIN_W       = DEF_PIN_W,
    parameter int SLOT_LSB    = DEF_SLOT_LSB,
    parameter int SLOT_W      = DEF_SLOT_W,
    parameter int NUM_LINES   = DEF_NUM_LINES,
    parameter int GROUP_LINES = DEF_GROUP_LINES,
    parameter int NUM_GROUPS  = NUM_LINES / GROUP_LINES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [DEVFN_W-1:0]    req_devfn,
    input  logic [PIN_W-1:0]      req_pin,
    input  logic                  req_level,
    input  logic [NUM_GROUPS-1:0] grp_enable,
    output logic [NUM_LINES-1:0]  irq_out
);
    localparam int IDX_W = SLOT_W + PIN_W;

    logic [IDX_W-1:0]     line_idx;
    logic                 line_hit;
    logic [NUM_LINES-1:0] line_sel;
    logic [NUM_LINES-1:0] raw_lines;

    irq_line_mapper #(
        .DEVFN_W  (DEVFN_W),
        .PIN_W    (PIN_W),
        .SLOT_LSB (SLOT_LSB),
        .SLOT_W   (SLOT_W),
        .NUM_LINES(NUM_LINES),
        .IDX_W    (IDX_W)
    ) u_mapper (
        .req_valid(req_valid),
        .req_devfn(req_devfn),
        .req_pin  (req_pin),
        .line_idx (line_idx),
        .line_hit (line_hit),
        .line_sel (line_sel)
    );

    irq_level_store #(
        .NUM_LINES(NUM_LINES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_sel (line_sel),
        .req_level(req_level),
        .raw_lines(raw_lines)
    );

    irq_group_gate #(
        .NUM_LINES  (NUM_LINES),
        .GROUP_LINES(GROUP_LINES),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_gate (
        .raw_lines (raw_lines),
        .grp_enable(grp_enable),
        .irq_out   (irq_out)
    );
endmodule

// File: rtl/pci_irq_router_checker.sv
// Module: pci_irq_router_checker
// Temporal checks on the router, bound into every instance of the top module.
module pci_irq_router_checker #(
    parameter int NUM_LINES   = 32,
    parameter int GROUP_LINES = 4,
    parameter int NUM_GROUPS  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_level,
    input logic [NUM_GROUPS-1:0] grp_enable,
    input logic [NUM_LINES-1:0]  irq_out,
    input logic [NUM_LINES-1:0]  raw_lines,
    input logic [NUM_LINES-1:0]  line_sel,
    input logic                  line_hit
);
    // R1: a reset edge leaves every stored level cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (raw_lines == '0));

    // R2: the mapper addresses at most one line per cycle.
    a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_sel));

    // R8: a request that misses the line range leaves all state unchanged.
    a_r8_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !line_hit) |=> $stable(raw_lines));

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
        localparam int GRP = n / GROUP_LINES;

        // R2: the selected line loads the request level.
        a_r2_load_level: assert property (@(posedge clk) disable iff (!rst_n)
            line_sel[n] |=> (raw_lines[n] == $past(req_level)));

        // R3: an unselected line keeps its stored level.
        a_r3_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
            !line_sel[n] |=> $stable(raw_lines[n]));

        // R5: a disabled group drives its lines low.
        a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_enable[GRP] |-> !irq_out[n]);
    end
endmodule

bind pci_irq_router pci_irq_router_checker #(
    .NUM_LINES  (NUM_LINES),
    .GROUP_LINES(GROUP_LINES),
    .NUM_GROUPS (NUM_GROUPS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_level (req_level),
    .grp_enable(grp_enable),
    .irq_out   (irq_out),
    .raw_lines (raw_lines),
    .line_sel  (line_sel),
    .line_hit  (line_hit)
);

// File: tb/pci_irq_router_bench.sv
`timescale 1ns/1ps
module pci_irq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_valid_n = 1'b0;
    logic [7:0]  req_devfn = '0;
    logic [1:0]  req_pin = '0;
    logic        req_level = 1'b0;
    logic [7:0]  grp_enable = 8'hFF;
    logic [1:0]  grp_enable_n = 2'b11;
    logic [31:0] irq_out;
    logic [7:0]  irq_out_n;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] model_raw = '0;

    always #2.5 clk = ~clk;

    pci_irq_router u_pci_irq_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_devfn(req_devfn),
        .req_pin(req_pin), .req_level(req_level), .grp_enable(grp_enable),
        .irq_out(irq_out)
    );

    // Narrow build: 8 lines, 2 groups; line numbers 8..15 fall outside it.
    pci_irq_router #(.NUM_LINES(8)) u_pci_irq_router_narrow (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_n), .req_devfn(req_devfn),
        .req_pin(req_pin), .req_level(req_level), .grp_enable(grp_enable_n),
        .irq_out(irq_out_n)
    );

    typedef struct packed {
        logic [7:0] devfn;
        logic [1:0] pin;
        logic       lvl;
        logic [7:0] en;
        logic [4:0] line;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 2'd0, 1'b1, 8'hFF, 5'd0},
        '{8'h08, 2'd1, 1'b1, 8'hFF, 5'd5},
        '{8'h10, 2'd2, 1'b1, 8'hFF, 5'd10},
        '{8'h18, 2'd3, 1'b1, 8'hFF, 5'd15},
        '{8'hE7, 2'd2, 1'b1, 8'hFF, 5'd2},
        '{8'h9D, 2'd0, 1'b1, 8'hFF, 5'd12},
        '{8'h08, 2'd1, 1'b0, 8'hFF, 5'd5},
        '{8'h10, 2'd3, 1'b1, 8'hFB, 5'd11},
        '{8'h18, 2'd3, 1'b0, 8'h00, 5'd15},
        '{8'h00, 2'd1, 1'b1, 8'h01, 5'd1}
    };

    function automatic logic [31:0] expand(input logic [7:0] en);
        logic [31:0] m;
        for (int n = 0; n < 32; n++) m[n] = en[n / 4];
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] d, input logic [1:0] p, input logic l, input logic narrow);
        @(negedge clk);
        req_devfn = d; req_pin = p; req_level = l;
        if (narrow) req_valid_n = 1'b1; else req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_valid_n = 1'b0;
    endtask

    initial begin
        #200000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset clears all lines.
        repeat (3) @(negedge clk);
        check("R1 reset main", irq_out, 32'h0);
        check("R1 reset narrow", {24'h0, irq_out_n}, 32'h0);
        rst_n = 1'b1;

        // R2/R4/R5/R7 table walk against a model of stored levels.
        for (int i = 0; i < NVEC; i++) begin
            grp_enable = VECS[i].en;
            strobe(VECS[i].devfn, VECS[i].pin, VECS[i].lvl, 1'b0);
            model_raw[VECS[i].line] = VECS[i].lvl;
            check("R2 R4 R5 R7 vector", irq_out, model_raw & expand(VECS[i].en));
            check("R9 upper lines low", {16'h0, irq_out[31:16]}, 32'h0);
        end

        // R3: no strobe, stored levels hold.
        grp_enable = 8'hFF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R3 hold without strobe", irq_out, model_raw);
        end

        // R5 then R6: level stored while disabled, then exposed by enable.
        grp_enable = 8'hFD;
        strobe(8'h08, 2'd2, 1'b1, 1'b0);
        model_raw[6] = 1'b1;
        check("R5 disabled group low", {31'h0, irq_out[6]}, 32'h0);
        grp_enable = 8'hFF;
        #1;
        check("R6 pending level exposed", irq_out, model_raw);

        // R8: narrow build drops requests above its last line.
        strobe(8'h08, 2'd3, 1'b1, 1'b1);
        check("R8 narrow in range", {24'h0, irq_out_n}, 32'h80);
        strobe(8'h10, 2'd0, 1'b1, 1'b1);
        check("R8 narrow line 8 ignored", {24'h0, irq_out_n}, 32'h80);
        strobe(8'h18, 2'd3, 1'b1, 1'b1);
        check("R8 narrow line 15 ignored", {24'h0, irq_out_n}, 32'h80);
        check("R8 main untouched", irq_out, model_raw);

        // R1: mid-run reset clears stored levels.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_raw = '0;
        check("R1 mid-run reset", irq_out, 32'h0);
        @(negedge clk);
        check("R1 stays clear", {24'h0, irq_out_n}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule